// File: doc/BRIEF.md
# Bunch-Locked Serial Command Transmitter

This block sends one 16-bit command word per bunch slot to a front-end readout chip. It uses three lines: a forwarded bit clock, a serial data line and a strobe that marks the first bit of every slot. Each word selects an analogue storage cell for writing or reading, or carries settings and readout control. An upstream source offers words through a valid/ready handshake. The slot cadence never depends on that source. If no word is offered when a slot is loaded, the all-zero no-operation word goes out instead.

A train-start pulse (`train_go`) restarts the slot sequence at bunch 0. The block then emits `TRAIN_LEN` slots back to back. After that the lines go quiet until the next pulse. The system clock `clk` is divided by `BIT_DIV` to give the bit period. Each slot lasts `SLOT_BITS` bit periods. The first 16 of those periods carry the word, most significant bit first. The remaining periods hold data low.

Top module: `bunch_cmd_tx`

## Requirements
- R1: While a train is running, `lnk_clk` is low for the first `BIT_DIV/2` system cycles of each bit period and high for the rest. `sdata` changes only at bit-period boundaries. Outside a train, `lnk_clk` is low.
- R2: In bit period i (0..15) of a slot, `sdata` equals bit 15-i of that slot's word. In bit periods 16 to `SLOT_BITS-1`, `sdata` is 0.
- R3: `strobe` is high exactly during bit period 0 of every slot and low at all other times.
- R4: If `cmd_valid` is low in the load cycle of a slot, that slot carries the word 16'h0000.
- R5: `cmd_ready` is high only in a load cycle. A load cycle is either a cycle with `train_go` high, or the last system cycle of a slot that is followed by another slot of the same train. A word is taken when `cmd_valid` and `cmd_ready` are both high, and it is sent in the next slot.
- R6: In the cycle after `train_go` is sampled high, bit 0 of slot 0 is on the lines. This holds even when `train_go` arrives in the middle of a running train.
- R7: After `TRAIN_LEN` slots, `sdata`, `strobe`, `lnk_clk` and `cmd_ready` stay low until the next `train_go`. A valid word held during that time is not consumed.
- R8: During reset and after reset until the first `train_go`, all outputs are low.
- R9: Within a train, slots start every `SLOT_BITS*BIT_DIV` system cycles, whatever the handshake does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| train_go | input | 1 | Single-cycle train start pulse |
| cmd_valid | input | 1 | Upstream word offered |
| cmd_word | input | 16 | Offered command word |
| cmd_ready | output | 1 | Word taken in this cycle if valid |
| lnk_clk | output | 1 | Forwarded bit clock to the chip |
| sdata | output | 1 | Serial command data |
| strobe | output | 1 | Slot-start marker, high for bit period 0 |

## Verification
The hardest situations to reach are the restart of a train in the middle of a slot and the boundary at the end of a train. At that boundary the last slot must not open a load window, and a word held valid must remain unconsumed. The stimulus runs a short train (a few slots) to completion while `cmd_valid` stays high into the quiet period. It then pulses `train_go` at an arbitrary phase partway through a later train. Valid patterns with gaps mix real words with no-operation slots around both events.

// File: rtl/bunch_cmd_pkg.sv
package bunch_cmd_pkg;
   localparam int CMD_W = 16;
   typedef logic [CMD_W-1:0] cmd_word_t;
   localparam cmd_word_t NOP_WORD = '0;
endpackage

// File: rtl/bct_bit_timer.sv
module bct_bit_timer #(
   parameter int BIT_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic run,
   output logic bit_end,
   output logic clk_hi
);
   localparam int PW = (BIT_DIV > 2) ? $clog2(BIT_DIV) : 1;

   initial begin
      if (BIT_DIV < 2 || (BIT_DIV % 2) != 0)
         $error("BIT_DIV must be even and at least 2");
   end

   generate
      if (BIT_DIV == 2) begin : g_toggle
         logic ph;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       ph <= 1'b0;
            else if (restart) ph <= 1'b0;
            else if (run)     ph <= ~ph;
         end
         assign bit_end = run && ph;
         assign clk_hi  = ph;
      end else begin : g_count
         logic [PW-1:0] ph;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       ph <= '0;
            else if (restart) ph <= '0;
            else if (run) begin
               if (ph == PW'(BIT_DIV - 1)) ph <= '0;
               else                        ph <= ph + 1'b1;
            end
         end
         assign bit_end = run && (ph == PW'(BIT_DIV - 1));
         assign clk_hi  = (ph >= PW'(BIT_DIV / 2));
      end
   endgenerate
endmodule

// File: rtl/bct_slot_seq.sv
module bct_slot_seq #(
   parameter int CMD_W     = 16,
   parameter int SLOT_BITS = 20,
   parameter int TRAIN_LEN = 2700
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic bit_end,
   output logic active,
   output logic slot_first,
   output logic in_payload,
   output logic load_now
);
   localparam int BW = $clog2(SLOT_BITS);
   localparam int SW = (TRAIN_LEN > 1) ? $clog2(TRAIN_LEN) : 1;

   initial begin
      if (SLOT_BITS < CMD_W) $error("SLOT_BITS must cover the command width");
      if (TRAIN_LEN < 1)     $error("TRAIN_LEN must be positive");
   end

   logic [BW-1:0] bit_idx;
   logic [SW-1:0] slot_cnt;
   logic          slot_last, more;

   assign slot_last  = active && bit_end && (bit_idx == BW'(SLOT_BITS - 1));
   assign more       = (slot_cnt != SW'(TRAIN_LEN - 1));
   assign load_now   = restart || (slot_last && more);
   assign slot_first = active && (bit_idx == '0);
   assign in_payload = (bit_idx < BW'(CMD_W));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b0;
         bit_idx  <= '0;
         slot_cnt <= '0;
      end else if (restart) begin
         active   <= 1'b1;
         bit_idx  <= '0;
         slot_cnt <= '0;
      end else if (slot_last) begin
         bit_idx <= '0;
         if (more) slot_cnt <= slot_cnt + 1'b1;
         else      active   <= 1'b0;
      end else if (active && bit_end) begin
         bit_idx <= bit_idx + 1'b1;
      end
   end
endmodule

// File: rtl/bct_shifter.sv
module bct_shifter
   import bunch_cmd_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      load,
   input  cmd_word_t load_word,
   input  logic      shift,
   output logic      msb
);
   cmd_word_t sh;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sh <= NOP_WORD;
      else if (load)  sh <= load_word;
      else if (shift) sh <= {sh[CMD_W-2:0], 1'b0};
   end
   assign msb = sh[CMD_W-1];
endmodule

// File: rtl/bunch_cmd_tx.sv
module bunch_cmd_tx
   import bunch_cmd_pkg::*;
#(
   parameter int SLOT_BITS = 20,
   parameter int BIT_DIV   = 2,
   parameter int TRAIN_LEN = 2700
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        train_go,
   input  logic        cmd_valid,
   input  logic [15:0] cmd_word,
   output logic        cmd_ready,
   output logic        lnk_clk,
   output logic        sdata,
   output logic        strobe
);
   logic      bit_end, clk_hi, active, slot_first, in_payload, load_now, msb;
   cmd_word_t next_word;

   assign next_word = cmd_valid ? cmd_word : NOP_WORD;

   bct_bit_timer #(.BIT_DIV(BIT_DIV)) u_tim (
      .clk(clk), .rst_n(rst_n), .restart(train_go), .run(active),
      .bit_end(bit_end), .clk_hi(clk_hi)
   );

   bct_slot_seq #(.CMD_W(CMD_W), .SLOT_BITS(SLOT_BITS), .TRAIN_LEN(TRAIN_LEN)) u_seq (
      .clk(clk), .rst_n(rst_n), .restart(train_go), .bit_end(bit_end),
      .active(active), .slot_first(slot_first), .in_payload(in_payload),
      .load_now(load_now)
   );

   bct_shifter u_sh (
      .clk(clk), .rst_n(rst_n), .load(load_now), .load_word(next_word),
      .shift(bit_end), .msb(msb)
   );

   assign cmd_ready = load_now;
   assign lnk_clk   = active && clk_hi;
   assign strobe    = slot_first;
   assign sdata     = active && in_payload && msb;

   // R1
   clk_rise_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lnk_clk) |-> $stable(sdata));
   // R2
   first_bit_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_ready && cmd_valid) |=> (strobe && sdata == $past(cmd_word[15])));
   // R4
   nop_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_ready && !cmd_valid) |=> !sdata);
   // R5
   load_then_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |=> strobe);
   // R7
   quiet_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (!sdata && !strobe && !lnk_clk));
endmodule

// File: tb/sim_bunch_cmd_tx.sv
module sim_bunch_cmd_tx;
   localparam int SB = 18;
   localparam int DV = 4;
   localparam int TL = 5;
   localparam int SC = SB * DV;

   logic clk = 0, rst_n = 0, train_go = 0, cmd_valid = 0;
   logic [15:0] cmd_word = '0;
   logic cmd_ready, lnk_clk, sdata, strobe;

   always #2.5 clk = ~clk;

   bunch_cmd_tx #(.SLOT_BITS(SB), .BIT_DIV(DV), .TRAIN_LEN(TL)) u0 (
      .clk(clk), .rst_n(rst_n), .train_go(train_go), .cmd_valid(cmd_valid),
      .cmd_word(cmd_word), .cmd_ready(cmd_ready), .lnk_clk(lnk_clk),
      .sdata(sdata), .strobe(strobe)
   );

   int n_cmp = 0, n_bad = 0, wc = 0, m_t = 0;
   bit m_act = 0, done = 0;
   logic [15:0] m_wr [0:TL-1];

   function automatic logic [15:0] word_of(int k);
      case (k % 4)
         1: return 16'hFFFF;
         2: return 16'h8001;
         default: return 16'hC35A ^ 16'(k * 16'h02B1);
      endcase
   endfunction

   task automatic chk(input logic act, input logic exp, input string tag);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s at %0t: got %b want %b", tag, $time, act, exp);
      end
   endtask

   task automatic cyc(input bit rst, input bit go, input bit vld);
      int sl, w, b, ph;
      bit er;
      @(negedge clk);
      sl = m_t / SC; w = m_t % SC; b = w / DV; ph = w % DV;
      chk(lnk_clk, m_act && ph >= DV / 2, rst ? "R8 lnk_clk" : "R1 lnk_clk");
      chk(strobe,  m_act && b == 0,       rst ? "R8 strobe"  : "R3/R9 strobe");
      chk(sdata,   m_act && b < 16 && m_wr[sl][15 - b], rst ? "R8 sdata" : "R2/R4 sdata");
      rst_n = !rst; train_go = go; cmd_valid = vld; cmd_word = word_of(wc);
      #1;
      er = !rst && (go || (m_act && ((m_t + 1) % SC == 0) && (m_t + 1) < TL * SC));
      chk(cmd_ready, er, m_act || go ? "R5 cmd_ready" : "R7 cmd_ready");
      if (rst) begin
         m_act = 0; m_t = 0;
      end else if (go) begin
         m_act = 1; m_t = 0; m_wr[0] = vld ? cmd_word : 16'h0;
         if (vld) wc++;
      end else if (m_act) begin
         if (er) begin
            m_wr[m_t / SC + 1] = vld ? cmd_word : 16'h0;
            if (vld) wc++;
         end
         m_t++;
         if (m_t == TL * SC) m_act = 0;
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(5ns * 150000);
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      for (int i = 0; i < TL; i++) m_wr[i] = '0;
      // R8: reset and idle before first train
      for (int i = 0; i < 4; i++) cyc(1, 0, 0);
      for (int i = 0; i < 6; i++) cyc(0, 0, 1);
      // R6, R2, R9: full train, words always offered; R7 valid held after end
      cyc(0, 1, 1);
      for (int i = 0; i < TL * SC + 20; i++) cyc(0, 0, 1);
      // R4: gappy valid pattern
      cyc(0, 1, 0);
      for (int i = 0; i < TL * SC + 10; i++) cyc(0, 0, (i % 3) != 0);
      // R4: no words at all, then R6 restart mid-slot
      cyc(0, 1, 0);
      for (int i = 0; i < SC + 29; i++) cyc(0, 0, 0);
      cyc(0, 1, 1);
      for (int i = 0; i < 2 * SC + 7; i++) cyc(0, 0, (i % 5) < 3);
      // R6: restart exactly at a slot's last cycle
      for (int i = 0; i < SC - 8; i++) cyc(0, 0, 1);
      cyc(0, 1, 1);
      for (int i = 0; i < TL * SC + 15; i++) cyc(0, 0, 1);
      finish_run();
   end
endmodule